// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O

The block gives a host three byte-wide parallel ports, called A, B and C, and a control register. All four sit behind a small register interface with a two-bit address, a chip select and separate read and write strobes. Each port has an output latch, an output value bus and a per-bit output enable. The output enable tells the pad ring whether the port drives its pins or listens to them.

A write to the control address carries one of two commands, and its top bit picks which one. A mode word sets the direction of port A, of port B and of each half of port C, and it clears every output latch. A single-bit command changes one bit of the port C latch. It leaves the directions and the other latches as they were. Only the basic I/O mode is built: each port or half-port is a plain input or a latched output.

Top module: `pio_triport`

## Requirements
- R1: After reset the stored mode word is 8Fh, every output enable is 0 (all ports are inputs) and every output latch is 0.
- R2: A write to address 3 with bit 7 set stores the whole byte as the mode word. A read of address 3 returns the last stored mode word.
- R3: In the mode word, bit 0 controls port A, bit 1 controls port B, bit 2 controls port C bits 3..0 and bit 3 controls port C bits 7..4. A 1 makes that group an input (enables 0), and a 0 makes it an output (enables 1). Bits 6..4 have no effect on direction.
- R4: A mode-word write clears the A, B and C output latches to 0 in the same cycle that it updates the directions.
- R5: A write to address 0, 1 or 2 loads the full byte into the latch of port A, B or C respectively. The latch value appears on that port's output bus whatever the port's direction.
- R6: A read of address 0, 1 or 2 returns, bit by bit, the live input pin where the bit is an input and the latch where it is an output.
- R7: A write to address 3 with bit 7 clear is a single-bit command. Bits 3..1 give the index of a port C bit (0 to 7), and bit 0 is the value written into that latch bit. Bits 6..4 are ignored.
- R8: A single-bit command changes no other port C latch bit, no port A or B latch, no output enable, and not the stored mode word.
- R9: Without chip select, writes change nothing. The read data bus is 0 whenever chip select and read are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A latch value |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B latch value |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C latch value |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
The bench builds the block with its default byte-wide data path. With that width, a full sweep is small. The bench writes all sixteen settings of the four direction bits, with different latch and pin patterns, and reads back every port. It also issues all sixteen index and value combinations of the single-bit command, with the ignored bits varied. For each one it checks the one latch bit that should move against the others that should stay put.

// File: rtl/pio_pkg.sv
package pio_pkg;
    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } pio_sel_e;

    // Field positions inside a control write
    localparam int CMD_KIND_BIT = 7;
    localparam int DIR_A_BIT    = 0;
    localparam int DIR_B_BIT    = 1;
    localparam int DIR_CLO_BIT  = 2;
    localparam int DIR_CHI_BIT  = 3;
    localparam int BSR_VAL_BIT  = 0;
endpackage

// File: rtl/pio_wr_decode.sv
module pio_wr_decode
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              cs,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic              kind_bit,
    output logic              mode_wr,
    output logic              bsr_wr,
    output logic [2:0]        port_wr
);
    logic acc;

    always_comb begin
        acc     = cs && wr;
        mode_wr = acc && (pio_sel_e'(addr) == SEL_CTRL) && kind_bit;
        bsr_wr  = acc && (pio_sel_e'(addr) == SEL_CTRL) && !kind_bit;
        port_wr = '0;
        if (acc) begin
            unique case (pio_sel_e'(addr))
                SEL_A:    port_wr[0] = 1'b1;
                SEL_B:    port_wr[1] = 1'b1;
                SEL_C:    port_wr[2] = 1'b1;
                default:  port_wr    = '0;
            endcase
        end
    end
endmodule

// File: rtl/pio_rd_merge.sv
module pio_rd_merge #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] latch_val,
    input  logic [DATA_W-1:0] pin_val,
    input  logic [DATA_W-1:0] oe,
    output logic [DATA_W-1:0] merged
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign merged[i] = oe[i] ? latch_val[i] : pin_val[i];
    end
endmodule

// File: rtl/pio_triport.sv
module pio_triport
    import pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_oe,
    input  logic [DATA_W-1:0] pc_in,
    output logic [DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0] pc_oe
);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] MODE_RST =
        (DATA_W'(1) << CMD_KIND_BIT) | DATA_W'(4'hF);

    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] la;
        logic [DATA_W-1:0] lb;
        logic [DATA_W-1:0] lc;
    } pio_state_t;

    pio_state_t st_d, st_q;

    logic       mode_wr, bsr_wr;
    logic [2:0] port_wr;
    logic [IDX_W-1:0] bit_idx;

    pio_wr_decode #(.DATA_W(DATA_W)) u_dec (
        .cs       (cs),
        .wr       (wr),
        .addr     (addr),
        .kind_bit (wdata[CMD_KIND_BIT]),
        .mode_wr  (mode_wr),
        .bsr_wr   (bsr_wr),
        .port_wr  (port_wr)
    );

    assign bit_idx = wdata[IDX_W:1];

    always_comb begin
        st_d = st_q;
        if (mode_wr) begin
            st_d.mode = wdata;
            st_d.la   = '0;
            st_d.lb   = '0;
            st_d.lc   = '0;
        end else if (bsr_wr) begin
            st_d.lc[bit_idx] = wdata[BSR_VAL_BIT];
        end else begin
            if (port_wr[0]) st_d.la = wdata;
            if (port_wr[1]) st_d.lb = wdata;
            if (port_wr[2]) st_d.lc = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RST;
            st_q.la   <= '0;
            st_q.lb   <= '0;
            st_q.lc   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Direction: mode bit 1 = input, so enable is its inverse
    assign pa_oe = {DATA_W{~st_q.mode[DIR_A_BIT]}};
    assign pb_oe = {DATA_W{~st_q.mode[DIR_B_BIT]}};
    assign pc_oe = {{(DATA_W-HALF_W){~st_q.mode[DIR_CHI_BIT]}},
                    {HALF_W{~st_q.mode[DIR_CLO_BIT]}}};

    assign pa_out = st_q.la;
    assign pb_out = st_q.lb;
    assign pc_out = st_q.lc;

    logic [DATA_W-1:0] rd_a, rd_b, rd_c;

    pio_rd_merge #(.DATA_W(DATA_W)) u_rd_a (
        .latch_val (st_q.la), .pin_val (pa_in), .oe (pa_oe), .merged (rd_a));
    pio_rd_merge #(.DATA_W(DATA_W)) u_rd_b (
        .latch_val (st_q.lb), .pin_val (pb_in), .oe (pb_oe), .merged (rd_b));
    pio_rd_merge #(.DATA_W(DATA_W)) u_rd_c (
        .latch_val (st_q.lc), .pin_val (pc_in), .oe (pc_oe), .merged (rd_c));

    always_comb begin
        rdata = '0;
        if (cs && rd) begin
            unique case (pio_sel_e'(addr))
                SEL_A:    rdata = rd_a;
                SEL_B:    rdata = rd_b;
                SEL_C:    rdata = rd_c;
                SEL_CTRL: rdata = st_q.mode;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pio_triport_chk.sv
module pio_triport_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              rd,
    input logic              wr,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] pa_out,
    input logic [DATA_W-1:0] pa_oe,
    input logic [DATA_W-1:0] pb_out,
    input logic [DATA_W-1:0] pb_oe,
    input logic [DATA_W-1:0] pc_out,
    input logic [DATA_W-1:0] pc_oe
);
    logic ctl_wr, mode_cmd, bsr_cmd;
    assign ctl_wr   = cs && wr && (addr == 2'd3);
    assign mode_cmd = ctl_wr && wdata[DATA_W-1];
    assign bsr_cmd  = ctl_wr && !wdata[DATA_W-1];

    assert_mode_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cmd |=> (pa_out == '0) && (pb_out == '0) && (pc_out == '0));

    assert_bsr_one_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_cmd |=> ($countones(pc_out ^ $past(pc_out)) <= 1));

    assert_bsr_keeps_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bsr_cmd |=> $stable(pa_out) && $stable(pb_out) && $stable(pa_oe)
                    && $stable(pb_oe) && $stable(pc_oe));

    assert_no_cs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out)
                && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> (rdata == '0));

    assert_dir_only_on_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_cmd |=> $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));
endmodule

bind pio_triport pio_triport_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .rd     (rd),
    .wr     (wr),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .pa_out (pa_out),
    .pa_oe  (pa_oe),
    .pb_out (pb_out),
    .pb_oe  (pb_oe),
    .pc_out (pc_out),
    .pc_oe  (pc_oe)
);

// File: tb/tb_pio_triport.sv
module tb_pio_triport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] m_mode, m_la, m_lb, m_lc;

    always #4 clk = ~clk;

    pio_triport dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, input bit sel);
        @(negedge clk);
        cs = sel; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    function automatic logic [7:0] oe_of(input logic [7:0] mode, input int port);
        case (port)
            0: return {8{~mode[0]}};
            1: return {8{~mode[1]}};
            default: return {{4{~mode[3]}}, {4{~mode[2]}}};
        endcase
    endfunction

    task automatic check_outs(input string req);
        check(pa_out == m_la, req, pa_out, m_la);
        check(pb_out == m_lb, req, pb_out, m_lb);
        check(pc_out == m_lc, req, pc_out, m_lc);
        check(pa_oe == oe_of(m_mode, 0), req, pa_oe, oe_of(m_mode, 0));
        check(pb_oe == oe_of(m_mode, 1), req, pb_oe, oe_of(m_mode, 1));
        check(pc_oe == oe_of(m_mode, 2), req, pc_oe, oe_of(m_mode, 2));
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        m_mode = 8'h8F; m_la = 0; m_lb = 0; m_lc = 0;
        check_outs("R1");
        rd_reg(2'd3, r);
        check(r == 8'h8F, "R1", r, 8'h8F);

        // R2..R6: sweep all direction settings
        for (int m = 0; m < 16; m++) begin
            logic [7:0] mw;
            mw = 8'h80 | 8'(m) | (8'(m) << 4 & 8'h70);
            wr_reg(2'd1, 8'hFF, 1'b1);               // dirty a latch first
            wr_reg(2'd3, mw, 1'b1);
            m_mode = mw; m_la = 0; m_lb = 0; m_lc = 0;
            check_outs("R3_R4");
            rd_reg(2'd3, r);
            check(r == mw, "R2", r, mw);
            m_la = 8'h3C ^ 8'(m); m_lb = 8'hA5 + 8'(m); m_lc = 8'(m * 17) ^ 8'h96;
            wr_reg(2'd0, m_la, 1'b1);
            wr_reg(2'd1, m_lb, 1'b1);
            wr_reg(2'd2, m_lc, 1'b1);
            check_outs("R5");
            pa_in = ~m_la; pb_in = 8'h5A ^ 8'(m); pc_in = 8'(m << 3) ^ 8'hC3;
            rd_reg(2'd0, r);
            e = (oe_of(m_mode, 0) & m_la) | (~oe_of(m_mode, 0) & pa_in);
            check(r == e, "R6", r, e);
            rd_reg(2'd1, r);
            e = (oe_of(m_mode, 1) & m_lb) | (~oe_of(m_mode, 1) & pb_in);
            check(r == e, "R6", r, e);
            rd_reg(2'd2, r);
            e = (oe_of(m_mode, 2) & m_lc) | (~oe_of(m_mode, 2) & pc_in);
            check(r == e, "R6", r, e);
        end

        // R7/R8: single-bit command sweep on an all-output setup
        wr_reg(2'd3, 8'h80, 1'b1);
        m_mode = 8'h80; m_la = 8'h11; m_lb = 8'h22; m_lc = 8'h5A;
        wr_reg(2'd0, m_la, 1'b1);
        wr_reg(2'd1, m_lb, 1'b1);
        wr_reg(2'd2, m_lc, 1'b1);
        for (int i = 0; i < 8; i++) begin
            for (int v = 0; v < 2; v++) begin
                logic [7:0] cmd;
                cmd = (8'(i) << 1) | 8'(v) | ((8'(i + v) & 8'h7) << 4);
                wr_reg(2'd3, cmd, 1'b1);
                m_lc[i] = v[0];
                check_outs("R7_R8");
                rd_reg(2'd3, r);
                check(r == 8'h80, "R8", r, 8'h80);
            end
        end

        // R9: writes without chip select are ignored, rdata idle is zero
        wr_reg(2'd3, 8'h8F, 1'b0);
        wr_reg(2'd0, 8'hEE, 1'b0);
        wr_reg(2'd2, 8'h07, 1'b0);
        check_outs("R9");
        @(negedge clk);
        rd = 1'b1; addr = 2'd3; cs = 1'b0;
        #1 check(rdata == 8'h00, "R9", rdata, 8'h00);
        rd = 1'b0;
        #1 check(rdata == 8'h00, "R9", rdata, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule